// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block decides when a copper Ethernet port starts or restarts auto-negotiation, how often link pulse bursts go out while the link is down, and what speed and duplex the port ends up with. It runs from the core clock. A one-cycle millisecond strobe paces the pulse timing. Control inputs come straight from the management register bits: negotiation enable, restart, power-down, power-saving enable, smart-speed enable and the forced speed and duplex selects.

During negotiation the sequencer emits a one-cycle pulse request at a fixed interval. The interval is 50 ms when power saving is on and 16 ms when it is off. Pulse requests stop as soon as the link is reported up. If a gigabit attempt fails and smart speed is on, the sequencer lowers its ceiling to 100 Mb/s and keeps negotiating. With smart speed off, it parks with the link down until something restarts it. Any restart clears the lowered ceiling. When negotiation is disabled, the speed and duplex come directly from the forced select bits. A partner without negotiation is resolved by parallel detection to half duplex at 10 or 100 Mb/s.

Top module: `lnk_bringup`

## Requirements
- R1: After reset the block is negotiating (`an_active`=1), `pulse_req`=0, and `speed` shows the gigabit ceiling. Speed codes: 2'b10 = 1000 Mb/s, 2'b01 = 100 Mb/s, 2'b00 = 10 Mb/s.
- R2: With `aps_en`=1 and `ms_tick` high every cycle, `pulse_req` is a one-cycle strobe every 50 ticks. The first strobe comes 50 ticks after reset.
- R3: With `aps_en`=0, the strobe comes every 16 ticks.
- R4: A change of `aps_en` restarts the interval at once. The next strobe comes a full new interval after the change edge.
- R5: `link_up` during negotiation clears `an_active` and stops all strobes. A later drop of `link_up` restarts negotiation, and the first strobe comes one full interval after the drop.
- R6: While `pwr_down`=1, `an_active` is 0 and no strobes are issued. Releasing `pwr_down` restarts negotiation. `an_restart` also restarts it from any state.
- R7: `giga_fail` during negotiation with `smart_en`=1 lowers the ceiling to 100 Mb/s (`speed`=2'b01) and negotiation continues.
- R8: `giga_fail` with `smart_en`=0 ends negotiation: `an_active`=0 and no strobes until a restart.
- R9: Every restart (reset, `an_restart`, power-down exit, link drop, re-enabling negotiation) clears the lowered ceiling back to gigabit.
- R10: With `an_en`=0: if `frc_hi`=1, `speed` is 2'b10; otherwise `speed` is 2'b01 when `frc_lo`=1 and 2'b00 when `frc_lo`=0. `full_dup` follows `frc_full`, `an_active` is 0 and no strobes are issued.
- R11: A link up by parallel detection (`pdet`=1) is half duplex, with `speed` 2'b01 if `pdet_100`=1 and 2'b00 otherwise.
- R12: A negotiated link (`pdet`=0) is full duplex at the current ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| an_en | input | 1 | Negotiation enable |
| an_restart | input | 1 | Restart negotiation request |
| pwr_down | input | 1 | Power-down control |
| aps_en | input | 1 | Power-saving slow pulse rate enable |
| smart_en | input | 1 | Gigabit-to-100 downshift enable |
| frc_hi | input | 1 | Forced speed select, high bit |
| frc_lo | input | 1 | Forced speed select, low bit |
| frc_full | input | 1 | Forced full duplex |
| link_up | input | 1 | Link established indication |
| giga_fail | input | 1 | Gigabit attempt failed strobe |
| pdet | input | 1 | Link came up by parallel detection |
| pdet_100 | input | 1 | Parallel detection found 100 Mb/s |
| pulse_req | output | 1 | Link pulse burst request strobe |
| an_active | output | 1 | Negotiation in progress |
| speed | output | 2 | Resolved speed code |
| full_dup | output | 1 | Resolved full duplex |

## Verification
A wrong interval counter shows up as a strobe gap other than 50 or 16 ticks. The error appears within one interval, so the bench measures the gap between consecutive strobes and after each reload event. A stale downshift flag shows as `speed` 2'b01 in the cycle after a restart. A wrong state shows within one cycle as an unexpected `an_active`, or as strobes that continue while the link is up, parked or powered down.

// File: rtl/lnk_bringup.sv
module lnk_bringup #(
  parameter int APS_MS = 50,
  parameter int FLP_MS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       an_en,
  input  logic       an_restart,
  input  logic       pwr_down,
  input  logic       aps_en,
  input  logic       smart_en,
  input  logic       frc_hi,
  input  logic       frc_lo,
  input  logic       frc_full,
  input  logic       link_up,
  input  logic       giga_fail,
  input  logic       pdet,
  input  logic       pdet_100,
  output logic       pulse_req,
  output logic       an_active,
  output logic [1:0] speed,
  output logic       full_dup
);
  localparam int CW = $clog2(APS_MS + 1);
  localparam logic [CW-1:0] APS_CNT = CW'(APS_MS);
  localparam logic [CW-1:0] FLP_CNT = CW'(FLP_MS);

  typedef enum logic [2:0] {S_OFF, S_FRC, S_NEG, S_UP, S_HOLD} st_t;

  st_t           st, nx;
  logic          dshift, nds, restart, aps_q, reload;
  logic [CW-1:0] cnt;
  logic [CW-1:0] intv;

  assign intv   = aps_en ? APS_CNT : FLP_CNT;
  assign reload = restart | (aps_en != aps_q);

  always_comb begin
    nx      = st;
    nds     = dshift;
    restart = 1'b0;
    if (pwr_down) nx = S_OFF;
    else if (!an_en) nx = S_FRC;
    else if (st == S_OFF || st == S_FRC || an_restart || (st == S_UP && !link_up)) begin
      nx      = S_NEG;
      nds     = 1'b0;
      restart = 1'b1;
    end else if (st == S_NEG) begin
      if (link_up) nx = S_UP;
      else if (giga_fail && !dshift) begin
        if (smart_en) nds = 1'b1;
        else          nx  = S_HOLD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_NEG;
      dshift    <= 1'b0;
      aps_q     <= 1'b1;
      cnt       <= APS_CNT;
      pulse_req <= 1'b0;
    end else begin
      st        <= nx;
      dshift    <= nds;
      aps_q     <= aps_en;
      pulse_req <= !reload && st == S_NEG && nx == S_NEG && ms_tick && cnt == CW'(1);
      if (reload) cnt <= intv;
      else if (st == S_NEG && ms_tick) cnt <= (cnt == CW'(1)) ? intv : cnt - CW'(1);
    end
  end

  assign an_active = (st == S_NEG);

  always_comb begin
    if (st == S_FRC)              speed = frc_hi ? 2'b10 : {1'b0, frc_lo};
    else if (st == S_UP && pdet)  speed = {1'b0, pdet_100};
    else                          speed = dshift ? 2'b01 : 2'b10;
  end

  assign full_dup = (st == S_FRC) ? frc_full : (st == S_UP && !pdet);
endmodule

module lnk_bringup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       an_en,
  input logic       an_restart,
  input logic       pwr_down,
  input logic       smart_en,
  input logic       link_up,
  input logic       giga_fail,
  input logic       pulse_req,
  input logic       an_active,
  input logic [1:0] speed
);
  AST_PULSE_FROM_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |-> $past(an_active && ms_tick)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |=> !pulse_req); // R2
  AST_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link_up) |-> !pulse_req); // R5
  AST_PDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !an_active); // R6
  AST_PDOWN_NOPULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && $past(pwr_down)) |-> !pulse_req); // R6
  AST_PDOWN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_down) && !pwr_down && an_en) |=> (an_active && speed == 2'b10)); // R9
  AST_FORCED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !an_en |=> !an_active); // R10
  AST_DOWNSHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (an_active && giga_fail && smart_en && !link_up && an_en && !pwr_down && !an_restart)
      |=> speed == 2'b01); // R7
endmodule

bind lnk_bringup lnk_bringup_chk chk_i (.*);

// File: tb/lnk_bringup_tb.sv
module lnk_bringup_tb_top;
  logic clk = 0, rst_n = 0;
  logic ms_tick = 1, an_en = 1, an_restart = 0, pwr_down = 0, aps_en = 1, smart_en = 1;
  logic frc_hi = 0, frc_lo = 0, frc_full = 0, link_up = 0, giga_fail = 0, pdet = 0, pdet_100 = 0;
  logic pulse_req, an_active, full_dup;
  logic [1:0] speed;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  lnk_bringup dut_i (.*);

  // {frc_hi, frc_lo, frc_full, expected speed[1:0], expected duplex}
  localparam logic [5:0] VEC [8] = '{
    6'b000_00_0, 6'b001_00_1, 6'b010_01_0, 6'b011_01_1,
    6'b100_10_0, 6'b101_10_1, 6'b110_10_0, 6'b111_10_1};

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse_req && n < 200);
  endtask

  task automatic quiet(int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (pulse_req) cnt++;
    end
  endtask

  task automatic strobe(ref logic s);
    s = 1;
    tick(1);
    s = 0;
  endtask

  initial begin
    int n;
    tick(3);
    rst_n = 1;
    chk(an_active == 1, "R1 an_active", an_active, 1);
    chk(pulse_req == 0, "R1 pulse", pulse_req, 0);
    chk(speed == 2'b10, "R1 speed", speed, 2);
    wait_pulse(n); chk(n == 50, "R2 first gap", n, 50);
    wait_pulse(n); chk(n == 50, "R2 gap", n, 50);
    tick(5);
    aps_en = 0;
    wait_pulse(n); chk(n == 17, "R4 reload", n, 17);
    wait_pulse(n); chk(n == 16, "R3 gap", n, 16);
    tick(3);
    link_up = 1;
    tick(1);
    chk(an_active == 0, "R5 an_active up", an_active, 0);
    chk(speed == 2'b10 && full_dup, "R12 giga full", {speed, full_dup}, 5);
    quiet(60, n); chk(n == 0, "R5 no pulse while up", n, 0);
    link_up = 0;
    wait_pulse(n); chk(n == 17, "R5 resume", n, 17);
    chk(an_active == 1, "R5 an_active down", an_active, 1);
    strobe(giga_fail);
    chk(speed == 2'b01 && an_active, "R7 downshift", {speed, an_active}, 3);
    link_up = 1;
    tick(1);
    chk(speed == 2'b01 && full_dup, "R12 100 full", {speed, full_dup}, 3);
    link_up = 0;
    tick(1);
    chk(speed == 2'b10, "R9 link drop clears", speed, 2);
    strobe(giga_fail);
    chk(speed == 2'b01, "R7 downshift again", speed, 1);
    strobe(an_restart);
    chk(speed == 2'b10 && an_active, "R9 restart clears", {speed, an_active}, 5);
    strobe(giga_fail);
    pwr_down = 1;
    tick(1);
    chk(an_active == 0, "R6 power down", an_active, 0);
    quiet(60, n); chk(n == 0, "R6 no pulse in power down", n, 0);
    pwr_down = 0;
    tick(1);
    chk(an_active && speed == 2'b10, "R6 R9 power-down exit", {speed, an_active}, 5);
    smart_en = 0;
    strobe(giga_fail);
    chk(an_active == 0, "R8 parked", an_active, 0);
    quiet(60, n); chk(n == 0, "R8 no pulse parked", n, 0);
    strobe(an_restart);
    chk(an_active == 1, "R8 restart leaves park", an_active, 1);
    smart_en = 1;
    pdet = 1; pdet_100 = 1; link_up = 1;
    tick(1);
    chk(speed == 2'b01 && !full_dup, "R11 pdet 100 half", {speed, full_dup}, 2);
    pdet_100 = 0;
    tick(1);
    chk(speed == 2'b00 && !full_dup, "R11 pdet 10 half", {speed, full_dup}, 0);
    link_up = 0; pdet = 0;
    an_en = 0;
    tick(1);
    for (int i = 0; i < 8; i++) begin
      {frc_hi, frc_lo, frc_full} = VEC[i][5:3];
      tick(1);
      chk(speed == VEC[i][2:1] && full_dup == VEC[i][0] && !an_active,
          "R10 forced", {an_active, speed, full_dup}, {1'b0, VEC[i][2:0]});
    end
    quiet(40, n); chk(n == 0, "R10 no pulse forced", n, 0);
    an_en = 1;
    tick(1);
    chk(an_active && speed == 2'b10, "R9 re-enable restarts", {speed, an_active}, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule